// File: doc/BRIEF.md
# Pointer-Selected Register Sequencer

An 8-bit sequencer datapath built around sixteen 16-bit general registers. No register is fixed as the program counter. A 4-bit pointer names the register that fetches instructions, and a second 4-bit pointer names the register that addresses data. Changing the program pointer moves execution to wherever the newly named register points. This is also how a subroutine is entered, because the instruction set has no call. Arithmetic on the register that is currently the program counter redirects control flow.

Every instruction starts with an opcode fetch through the program register. The block then executes in one, two or three more cycles, depending on how many operand bytes it needs. The memory side is one synchronous byte port: read data is valid in the cycle after the address is presented, and a write takes effect on the clock edge at the end of the cycle in which the write enable is high. Four flag inputs can steer branches, and one output flag bit is under program control. Opcode encodings use the high nibble as the operation and the low nibble as a register index or condition code. Every opcode not listed below behaves as a no-operation.

Top module: `ptr_seq_core`

## Requirements
- R1: Each of the sixteen registers holds 16 bits. 0x1N increments register N and 0x2N decrements it, both modulo 2^16. 0x6N copies the low byte of register N into the accumulator D, and 0x7N copies the high byte. 0x8N writes D into the low byte of register N, and 0x9N writes D into the high byte.
- R2: 0xDN makes register N the program register, and the next opcode is fetched from the address that register N holds. 0xEN makes register N the data register. A register that stops being the program register keeps its value, so switching back resumes just after the switching opcode.
- R3: 0xC0 loads D from memory at the data register's address. 0xC1 ORs that memory byte into D. 0xC2 loads D from the byte that follows the opcode. 0x5N writes D to memory at the address held in register N.
- R4: Incrementing or decrementing the register that is currently the program register changes the address of the next fetch by the same amount.
- R5: 0x3c is a short branch with condition code c and a one-byte operand. When taken, only the low byte of the program register is replaced by the operand. The high byte stays the high byte of the operand's own address.
- R6: Condition code c: c[2:0]=0 always true, 1 = output flag, 2 = D equal to zero, 3 = never, 4 to 7 = flag_i[c-4]. c[3]=1 inverts the result.
- R7: 0xBc is a long branch with condition code c, followed by two address bytes, high byte first. When taken, all 16 bits of the program register are loaded. When not taken, execution continues after both bytes.
- R8: Every opcode or operand fetch advances the program register by one, modulo 2^16. A short branch that is not taken continues at the byte after its operand.
- R9: Reset clears both pointers, D, the output flag and every register. Execution therefore starts at address 0 with register 0 as the program register.
- R10: 0xAx sets q_o to x[0].
- R11: fetch_o is high exactly in opcode fetch cycles. A 0x5N store drives mem_we_o high for one cycle, in the cycle after its opcode fetch, with mem_addr_o equal to register N and mem_wdata_o equal to D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 16 | Memory byte address |
| mem_we_o | output | 1 | Memory write enable |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, one cycle after the address |
| fetch_o | output | 1 | High in opcode fetch cycles |
| flag_i | input | 4 | External condition flags |
| q_o | output | 1 | Program-controlled output flag |

## Verification
The assertions assume that the memory behaves as a synchronous byte store, returning data one cycle after the address. They also assume that flag_i stays stable for the whole of a branch instruction, since the condition is evaluated at the operand byte. The bench models exactly that memory and holds the flags constant for each run. It changes them only while reset is held, and it sweeps every condition code against every flag pattern, both output flag states and both D-zero states.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int unsigned OP_W   = 8;
  localparam int unsigned FLAG_N = 4;

  typedef enum logic [1:0] {ST_FETCH, ST_EXEC, ST_OPND, ST_OPND2} state_e;

  typedef enum logic [3:0] {
    K_NOP, K_INC, K_DEC, K_SBR, K_STR, K_GLO, K_GHI, K_PLO,
    K_PHI, K_QSET, K_LBR, K_LDX, K_OR, K_LDI, K_SETP, K_SETX
  } kind_e;

  typedef struct packed {
    kind_e      kind;
    logic [3:0] n;
  } ctl_t;
endpackage

// File: rtl/seq_decode.sv
module seq_decode
  import seq_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output ctl_t            ctl_o
);
  always_comb begin
    ctl_o.n    = op_i[3:0];
    ctl_o.kind = K_NOP;
    case (op_i[7:4])
      4'h1: ctl_o.kind = K_INC;
      4'h2: ctl_o.kind = K_DEC;
      4'h3: ctl_o.kind = K_SBR;
      4'h5: ctl_o.kind = K_STR;
      4'h6: ctl_o.kind = K_GLO;
      4'h7: ctl_o.kind = K_GHI;
      4'h8: ctl_o.kind = K_PLO;
      4'h9: ctl_o.kind = K_PHI;
      4'hA: ctl_o.kind = K_QSET;
      4'hB: ctl_o.kind = K_LBR;
      4'hC: begin
        case (op_i[3:0])
          4'h0:    ctl_o.kind = K_LDX;
          4'h1:    ctl_o.kind = K_OR;
          4'h2:    ctl_o.kind = K_LDI;
          default: ctl_o.kind = K_NOP;
        endcase
      end
      4'hD: ctl_o.kind = K_SETP;
      4'hE: ctl_o.kind = K_SETX;
      default: ctl_o.kind = K_NOP;
    endcase
  end
endmodule

// File: rtl/seq_cond.sv
module seq_cond
  import seq_pkg::*;
(
  input  logic [3:0]        code_i,
  input  logic              q_i,
  input  logic              d_zero_i,
  input  logic [FLAG_N-1:0] flag_i,
  output logic              taken_o
);
  logic base;

  always_comb begin
    case (code_i[2:0])
      3'd0:    base = 1'b1;
      3'd1:    base = q_i;
      3'd2:    base = d_zero_i;
      3'd3:    base = 1'b0;
      default: base = flag_i[code_i[1:0]];
    endcase
    taken_o = base ^ code_i[3];
  end
endmodule

// File: rtl/seq_regfile.sv
module seq_regfile #(
  parameter  int unsigned NREG  = 16,
  parameter  int unsigned REG_W = 16,
  localparam int unsigned IDX_W = $clog2(NREG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [IDX_W-1:0] raddr_p_i,
  input  logic [IDX_W-1:0] raddr_x_i,
  input  logic [IDX_W-1:0] raddr_n_i,
  output logic [REG_W-1:0] rdata_p_o,
  output logic [REG_W-1:0] rdata_x_o,
  output logic [REG_W-1:0] rdata_n_o
);
  logic [REG_W-1:0] regs [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(NREG); i++) regs[i] <= '0;
    end else if (we_i) begin
      regs[waddr_i] <= wdata_i;
    end
  end

  assign rdata_p_o = regs[raddr_p_i];
  assign rdata_x_o = regs[raddr_x_i];
  assign rdata_n_o = regs[raddr_n_i];
endmodule

// File: rtl/ptr_seq_core.sv
module ptr_seq_core
  import seq_pkg::*;
#(
  parameter  int unsigned DATA_W = 8,
  parameter  int unsigned NREG   = 16,
  localparam int unsigned REG_W  = 2 * DATA_W,
  localparam int unsigned IDX_W  = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [REG_W-1:0]  mem_addr_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              fetch_o,
  input  logic [FLAG_N-1:0] flag_i,
  output logic              q_o
);
  state_e            state_q, state_d;
  logic [IDX_W-1:0]  p_q, p_d, x_q, x_d;
  logic [DATA_W-1:0] d_q, d_d, hi_q, hi_d;
  logic [OP_W-1:0]   ir_q;
  logic              q_q, q_d;

  logic              rf_we;
  logic [IDX_W-1:0]  rf_waddr;
  logic [REG_W-1:0]  rf_wdata;
  logic [REG_W-1:0]  pc_val, x_val, n_val;

  logic [OP_W-1:0]   op_sel;
  ctl_t              ctl;
  logic              taken;

  // opcode is decoded straight off the bus in EXEC, from ir_q afterwards
  assign op_sel = (state_q == ST_EXEC) ? mem_rdata_i : ir_q;

  seq_decode u_dec (.op_i(op_sel), .ctl_o(ctl));

  seq_cond u_cond (
    .code_i  (ctl.n),
    .q_i     (q_q),
    .d_zero_i(d_q == '0),
    .flag_i  (flag_i),
    .taken_o (taken)
  );

  seq_regfile #(.NREG(NREG), .REG_W(REG_W)) u_rf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (rf_we),
    .waddr_i  (rf_waddr),
    .wdata_i  (rf_wdata),
    .raddr_p_i(p_q),
    .raddr_x_i(x_q),
    .raddr_n_i(IDX_W'(ctl.n)),
    .rdata_p_o(pc_val),
    .rdata_x_o(x_val),
    .rdata_n_o(n_val)
  );

  always_comb begin
    state_d     = ST_FETCH;
    rf_we       = 1'b0;
    rf_waddr    = p_q;
    rf_wdata    = pc_val + REG_W'(1);
    mem_addr_o  = pc_val;
    mem_we_o    = 1'b0;
    mem_wdata_o = d_q;
    p_d         = p_q;
    x_d         = x_q;
    d_d         = d_q;
    q_d         = q_q;
    hi_d        = hi_q;
    case (state_q)
      ST_FETCH: begin
        rf_we   = 1'b1;
        state_d = ST_EXEC;
      end
      ST_EXEC: begin
        case (ctl.kind)
          K_INC: begin
            rf_we    = 1'b1;
            rf_waddr = IDX_W'(ctl.n);
            rf_wdata = n_val + REG_W'(1);
          end
          K_DEC: begin
            rf_we    = 1'b1;
            rf_waddr = IDX_W'(ctl.n);
            rf_wdata = n_val - REG_W'(1);
          end
          K_GLO: d_d = n_val[DATA_W-1:0];
          K_GHI: d_d = n_val[REG_W-1:DATA_W];
          K_PLO: begin
            rf_we    = 1'b1;
            rf_waddr = IDX_W'(ctl.n);
            rf_wdata = {n_val[REG_W-1:DATA_W], d_q};
          end
          K_PHI: begin
            rf_we    = 1'b1;
            rf_waddr = IDX_W'(ctl.n);
            rf_wdata = {d_q, n_val[DATA_W-1:0]};
          end
          K_STR: begin
            mem_addr_o = n_val;
            mem_we_o   = 1'b1;
          end
          K_QSET: q_d = ctl.n[0];
          K_SETP: p_d = IDX_W'(ctl.n);
          K_SETX: x_d = IDX_W'(ctl.n);
          K_SBR, K_LDI: state_d = ST_OPND;
          K_LBR: begin
            rf_we   = 1'b1;  // step past the high address byte now
            state_d = ST_OPND;
          end
          K_LDX, K_OR: begin
            mem_addr_o = x_val;
            state_d    = ST_OPND;
          end
          default: ;
        endcase
      end
      ST_OPND: begin
        case (ctl.kind)
          K_LDI: begin
            d_d   = mem_rdata_i;
            rf_we = 1'b1;
          end
          K_SBR: begin
            rf_we = 1'b1;
            if (taken) rf_wdata = {pc_val[REG_W-1:DATA_W], mem_rdata_i};
          end
          K_LDX: d_d = mem_rdata_i;
          K_OR:  d_d = d_q | mem_rdata_i;
          K_LBR: begin
            hi_d    = mem_rdata_i;
            rf_we   = 1'b1;
            state_d = ST_OPND2;
          end
          default: ;
        endcase
      end
      ST_OPND2: begin
        if (taken) begin
          rf_we    = 1'b1;
          rf_wdata = {hi_q, mem_rdata_i};
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FETCH;
      p_q     <= '0;
      x_q     <= '0;
      d_q     <= '0;
      q_q     <= 1'b0;
      hi_q    <= '0;
      ir_q    <= '0;
    end else begin
      state_q <= state_d;
      p_q     <= p_d;
      x_q     <= x_d;
      d_q     <= d_d;
      q_q     <= q_d;
      hi_q    <= hi_d;
      if (state_q == ST_EXEC) ir_q <= mem_rdata_i;
    end
  end

  assign fetch_o = (state_q == ST_FETCH);
  assign q_o     = q_q;

  // R8
  fetch_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FETCH) |=> (pc_val == $past(pc_val) + REG_W'(1)));

  // R8
  sbr_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OPND && ctl.kind == K_SBR && !taken)
      |=> (pc_val == $past(pc_val) + REG_W'(1)));

  // R5
  sbr_page_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OPND && ctl.kind == K_SBR && taken)
      |=> (pc_val == {$past(pc_val[REG_W-1:DATA_W]), $past(mem_rdata_i)}));

  // R7
  lbr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OPND2 && taken) |=> (pc_val == {$past(hi_q), $past(mem_rdata_i)}));

  // R3
  or_merge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OPND && ctl.kind == K_OR) |=> (d_q == ($past(d_q) | $past(mem_rdata_i))));

  // R10
  q_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_EXEC) |=> $stable(q_q));

  // R2
  p_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_EXEC) |=> $stable(p_q));
endmodule

// File: tb/sim_ptr_seq_core.sv
`timescale 1ns/1ps
module sim_ptr_seq_core;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] mem_addr;
  logic        mem_we;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 8'h00;
  logic        fetch;
  logic [3:0]  flags = 4'h0;
  logic        q;
  logic        ld_en = 1'b0;
  logic [15:0] ld_addr = 16'h0;
  logic [7:0]  ld_data = 8'h0;
  logic [7:0]  mem [4096];
  int          checks = 0;
  int          fails = 0;

  always #10 clk = ~clk;

  ptr_seq_core u0 (
    .clk_i(clk), .rst_ni(rst_ni), .mem_addr_o(mem_addr), .mem_we_o(mem_we),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .fetch_o(fetch),
    .flag_i(flags), .q_o(q)
  );

  always @(posedge clk) begin
    if (ld_en) mem[ld_addr[11:0]] <= ld_data;
    else if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[11:0]];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [15:0] a, input logic [7:0] v);
    ld_en = 1'b1; ld_addr = a; ld_data = v;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic hold_reset();
    rst_ni = 1'b0;
    @(negedge clk);
  endtask

  task automatic run(input int n, output logic [15:0] pc);
    rst_ni = 1'b1;
    repeat (n) @(negedge clk);
    while (!fetch) @(negedge clk);
    pc = mem_addr;
  endtask

  task automatic halt_at(input logic [15:0] a);
    put(a, 8'h30);
    put(a + 16'd1, a[7:0]);
  endtask

  function automatic logic exp_taken(input logic [3:0] c, input logic qv, input logic dz,
                                     input logic [3:0] f);
    logic b;
    case (c[2:0])
      3'd0:    b = 1'b1;
      3'd1:    b = qv;
      3'd2:    b = dz;
      3'd3:    b = 1'b0;
      default: b = f[c[1:0]];
    endcase
    return b ^ c[3];
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #(20 * 190000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] pc;
    logic [7:0] av [4] = '{8'h00, 8'h0F, 8'hA5, 8'hFF};
    logic [7:0] bv [4] = '{8'h00, 8'hF0, 8'h5A, 8'h81};
    @(negedge clk);

    // R9: state while held in reset
    hold_reset();
    chk("R9 fetch in reset", fetch, 1);
    chk("R9 addr in reset", mem_addr, 0);
    chk("R9 q in reset", q, 0);
    chk("R9 we in reset", mem_we, 0);
    // R9: D cleared -> D==0 branch taken
    put(0, 8'h32); put(1, 8'h20); halt_at(2); halt_at(16'h20);
    run(30, pc);
    chk("R9 D zero after reset", pc, 16'h0020);

    // R11: store timing
    hold_reset();
    put(0, 8'hC2); put(1, 8'h00); put(2, 8'h91); put(3, 8'hC2); put(4, 8'h80);
    put(5, 8'h81); put(6, 8'hC2); put(7, 8'h3C); put(8, 8'h51); halt_at(9);
    put(16'h0080, 8'h00);
    rst_ni = 1'b1;
    repeat (13) @(negedge clk);
    chk("R11 fetch flag", fetch, 1);
    chk("R11 fetch addr", mem_addr, 16'h0008);
    chk("R11 no write at fetch", mem_we, 0);
    @(negedge clk);
    chk("R11 write enable", mem_we, 1);
    chk("R11 write addr", mem_addr, 16'h0080);
    chk("R11 write data", mem_wdata, 8'h3C);
    chk("R11 fetch low on exec", fetch, 0);
    repeat (10) @(negedge clk);
    chk("R3 stored byte", mem[12'h080], 8'h3C);

    // R10: output flag
    hold_reset();
    put(0, 8'hA1); halt_at(1);
    run(20, pc);
    chk("R10 set q", q, 1);
    hold_reset();
    put(0, 8'hA1); put(1, 8'hA0); halt_at(2);
    run(20, pc);
    chk("R10 clear q", q, 0);

    // R4: increment of the program register skips a byte
    hold_reset();
    put(0, 8'h10); put(1, 8'hA1); halt_at(2);
    run(20, pc);
    chk("R4 inc pc target", pc, 16'h0002);
    chk("R4 skipped byte", q, 0);

    // R6 R5 R8: short branch sweep
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 16; f++)
        for (int qv = 0; qv < 2; qv++)
          for (int dz = 0; dz < 2; dz++) begin
            hold_reset();
            flags = 4'(f);
            put(0, {7'b1010000, 1'(qv)});
            put(1, 8'hC2); put(2, dz[0] ? 8'h00 : 8'h5A);
            put(3, {4'h3, 4'(c)}); put(4, 8'h20);
            halt_at(5); halt_at(16'h20);
            run(30, pc);
            chk("R6 short branch condition", pc,
                exp_taken(4'(c), 1'(qv), 1'(dz), 4'(f)) ? 16'h0020 : 16'h0005);
          end

    // R7: long branch sweep
    for (int c = 0; c < 16; c++) begin
      hold_reset();
      flags = 4'b1010;
      put(0, 8'hA1); put(1, 8'hC2); put(2, 8'h01);
      put(3, {4'hB, 4'(c)}); put(4, 8'h12); put(5, 8'h34);
      halt_at(6); halt_at(16'h1234);
      run(30, pc);
      chk("R7 long branch", pc, exp_taken(4'(c), 1'b1, 1'b0, 4'b1010) ? 16'h1234 : 16'h0006);
    end
    flags = 4'h0;

    // R5: page dependence of short branch
    hold_reset();
    put(0, 8'hB0); put(1, 8'h12); put(2, 8'hFE);
    put(16'h12FE, 8'h30); put(16'h12FF, 8'h40); halt_at(16'h1240);
    run(30, pc);
    chk("R5 short branch same page", pc, 16'h1240);
    hold_reset();
    put(0, 8'hB0); put(1, 8'h12); put(2, 8'hFF);
    put(16'h12FF, 8'h30); put(16'h1300, 8'h50); halt_at(16'h1350);
    run(30, pc);
    chk("R5 short branch operand on next page", pc, 16'h1350);

    // R2: program pointer switch and return
    for (int p = 1; p < 16; p++) begin
      hold_reset();
      put(0, 8'hC2); put(1, 8'h40 + 8'(p)); put(2, {4'h9, 4'(p)});
      put(3, 8'hC2); put(4, 8'h10); put(5, {4'h8, 4'(p)});
      put(6, {4'hD, 4'(p)}); halt_at(7);
      put({8'h40 + 8'(p), 8'h10}, 8'hA1); put({8'h40 + 8'(p), 8'h11}, 8'hD0);
      run(40, pc);
      chk("R2 return to register 0", pc, 16'h0007);
      chk("R2 routine ran", q, 1);
    end

    // R1: byte moves and inc/dec per register
    for (int n = 1; n < 16; n++) begin
      hold_reset();
      put({8'h10 + 8'(n), 8'h20 + 8'(n)}, 8'h00);
      put({8'h10 + 8'(n), 8'h21 + 8'(n)}, 8'h00);
      put({8'h10 + 8'(n), 8'h1F + 8'(n)}, 8'h00);
      put(0, 8'hC2); put(1, 8'h10 + 8'(n)); put(2, {4'h9, 4'(n)});
      put(3, 8'hC2); put(4, 8'h20 + 8'(n)); put(5, {4'h8, 4'(n)});
      put(6, {4'h6, 4'(n)}); put(7, {4'h5, 4'(n)});
      put(8, {4'h7, 4'(n)}); put(9, {4'h1, 4'(n)}); put(10, {4'h5, 4'(n)});
      put(11, {4'h2, 4'(n)}); put(12, {4'h2, 4'(n)}); put(13, {4'h5, 4'(n)});
      halt_at(14);
      run(60, pc);
      chk("R1 low byte store", mem[{4'(n), 8'h20 + 8'(n)}], 8'h20 + 8'(n));
      chk("R1 high byte after inc", mem[{4'(n), 8'h21 + 8'(n)}], 8'h10 + 8'(n));
      chk("R1 after dec", mem[{4'(n), 8'h1F + 8'(n)}], 8'h10 + 8'(n));
    end

    // R1: 16-bit wrap and borrow across bytes
    hold_reset();
    put(16'h02FF, 8'h00);
    put(0, 8'hC2); put(1, 8'hFF); put(2, 8'h93); put(3, 8'h83); put(4, 8'h13);
    put(5, 8'hC2); put(6, 8'h77); put(7, 8'h53);
    put(8, 8'hC2); put(9, 8'h03); put(10, 8'h94); put(11, 8'hC2); put(12, 8'h00);
    put(13, 8'h84); put(14, 8'h24); put(15, 8'hC2); put(16, 8'h66); put(17, 8'h54);
    halt_at(18);
    run(60, pc);
    chk("R1 inc wraps to 0", mem[0], 8'h77);
    chk("R1 dec borrows", mem[12'h2FF], 8'h66);

    // R3: OR sweep over data registers
    for (int xr = 1; xr < 16; xr++)
      for (int ai = 0; ai < 4; ai++)
        for (int bi = 0; bi < 4; bi++) begin
          hold_reset();
          put({8'h01, 8'(xr)}, bv[bi]);
          put(0, 8'hC2); put(1, 8'h01); put(2, {4'h9, 4'(xr)});
          put(3, 8'hC2); put(4, 8'(xr)); put(5, {4'h8, 4'(xr)});
          put(6, {4'hE, 4'(xr)}); put(7, 8'hC2); put(8, av[ai]);
          put(9, 8'hC1); put(10, {4'h5, 4'(xr)}); halt_at(11);
          run(40, pc);
          chk("R3 OR result", mem[{4'h1, 8'(xr)}], av[ai] | bv[bi]);
        end

    // R3: load through data register
    hold_reset();
    put(16'h0107, 8'hC5); put(16'h0108, 8'h00);
    put(0, 8'hC2); put(1, 8'h01); put(2, 8'h97); put(3, 8'hC2); put(4, 8'h07);
    put(5, 8'h87); put(6, 8'hE7); put(7, 8'hC0); put(8, 8'h17); put(9, 8'h57);
    halt_at(10);
    run(40, pc);
    chk("R3 load via data register", mem[12'h108], 8'hC5);

    summary();
    $finish;
  end
endmodule